// File: doc/BRIEF.md
# RAM Controller Interrupt and Configuration Registers

This block is the register file of an on-chip RAM controller. It sits on a simple word-addressed bus with 32-bit words and little-endian byte order. It accepts only whole-word accesses, so there are no byte strobes. It collects hardware event pulses into an interrupt status register, gates them with a mask, and drives one level-sensitive interrupt line toward the interrupt controller.

The mask is read-only. A set mask bit means that source is masked. Software changes the mask only through two write-only registers: one clears mask bits and so enables sources, the other sets mask bits and so disables them.

The block also holds three more registers:
- a small error-control register;
- an implementation register that reports the configured RAM size as a code;
- a read-only ready-debug register.

The RAM size comes from the parameter `RAM_KIB`. The supported sizes are 64, 128, 256, 512 and 1024 KiB. Any other value stops elaboration.

Top module: `ramc_irq_regs`

## Requirements
- R1: The status register sits at word offset 0 and uses bits [10:0]. Bits [31:11] read as zero. A pulse on `evt_i[k]` sets status bit k at the next clock edge.
- R2: Writing 1 to a status bit clears it, and bits written as 0 are kept. If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R3: The mask register sits at offset 1 and resets to 0x7FF, so all sources start masked. Bus writes to it change nothing.
- R4: Writing the enable register at offset 2 clears every mask bit written as 1. The enable register reads as 0.
- R5: Writing the disable register at offset 3 sets every mask bit written as 1. The disable register reads as 0.
- R6: `irq_o` is high exactly when some status bit is set whose mask bit is clear. It follows register changes in the cycle after the clock edge that made them.
- R7: The error-control register sits at offset 4. It is 4 bits wide, in bits [3:0], read and write, and resets to 0xF. Its upper bits read as zero.
- R8: The implementation register sits at offset 5. Its bits [3:0] are read-only and hold the RAM size code: 64 KiB=0, 128 KiB=1, 256 KiB=2, 512 KiB=3, 1 MiB=4. The default size of 1 MiB reads as 4.
- R9: The ready-debug register sits at offset 6. It is a read-only 16-bit field that reads as 0xFFFF.
- R10: A read from an unmapped offset (7 to 15) returns zero, and a write to one has no effect. `rdata_o` is zero whenever no read is requested.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write (1) or read (0) |
| addr_i | input | ADDR_W | Word offset |
| wdata_i | input | 32 | Write data |
| evt_i | input | NUM_SRC | Hardware event pulses, one per status bit |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Level interrupt |

## Verification
The checker takes for granted that bus controls and event inputs are known, 0 or 1, at every sampled edge. It also assumes that a write lasts exactly one cycle, so that at most one register is updated per edge. The stimulus keeps to this by driving all inputs on the falling edge and holding each access for a single cycle. It returns the bus to idle or to a read between writes, and asserts events only in the cycles where it intends a set/clear race.

// File: rtl/ramc_irq_pkg.sv
package ramc_irq_pkg;

  localparam int unsigned DATA_W = 32;

  localparam int unsigned OFF_STAT = 0;
  localparam int unsigned OFF_MASK = 1;
  localparam int unsigned OFF_EN   = 2;
  localparam int unsigned OFF_DIS  = 3;
  localparam int unsigned OFF_ECTL = 4;
  localparam int unsigned OFF_IMPL = 5;
  localparam int unsigned OFF_DBG  = 6;

  localparam logic [3:0] SIZE_BAD = 4'hF;

  function automatic logic [3:0] size_code(int unsigned kib);
    case (kib)
      64:      return 4'd0;
      128:     return 4'd1;
      256:     return 4'd2;
      512:     return 4'd3;
      1024:    return 4'd4;
      default: return SIZE_BAD;
    endcase
  endfunction

endpackage

// File: rtl/ramc_irq_status.sv
module ramc_irq_status #(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               clr_we_i,
  input  logic               en_we_i,
  input  logic               dis_we_i,
  input  logic [NUM_SRC-1:0] wbits_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_o
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic s_q, m_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s_q <= 1'b0;
        m_q <= 1'b1;
      end else begin
        // event set has priority over write-one-to-clear
        if (evt_i[i])                   s_q <= 1'b1;
        else if (clr_we_i && wbits_i[i]) s_q <= 1'b0;
        if (en_we_i && wbits_i[i])       m_q <= 1'b0;
        else if (dis_we_i && wbits_i[i]) m_q <= 1'b1;
      end
    end

    assign stat_o[i] = s_q;
    assign mask_o[i] = m_q;
  end

  assign irq_o = |(stat_o & ~mask_o);

endmodule

// File: rtl/ramc_irq_cfg.sv
module ramc_irq_cfg
  import ramc_irq_pkg::*;
#(
  parameter int unsigned RAM_KIB = 1024,
  parameter int unsigned CTRL_W  = 4,
  parameter int unsigned DBG_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [CTRL_W-1:0] ctl_wbits_i,
  output logic [CTRL_W-1:0] ctl_o,
  output logic [3:0]        impl_o,
  output logic [DBG_W-1:0]  dbg_o
);

  localparam logic [3:0] SIZE_CODE = size_code(RAM_KIB);

  if (SIZE_CODE == SIZE_BAD) begin : g_bad_size
    $error("ramc_irq_cfg: unsupported RAM_KIB %0d", RAM_KIB);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_o <= '1;
    else if (ctl_we_i) ctl_o <= ctl_wbits_i;
  end

  assign impl_o = SIZE_CODE;
  assign dbg_o  = '1;

endmodule

// File: rtl/ramc_irq_rdmux.sv
module ramc_irq_rdmux
  import ramc_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned CTRL_W  = 4,
  parameter int unsigned DBG_W   = 16
) (
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_SRC-1:0] stat_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [CTRL_W-1:0] ctl_i,
  input  logic [3:0]        impl_i,
  input  logic [DBG_W-1:0]  dbg_i,
  output logic [DATA_W-1:0] rdata_o
);

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr_i)
        ADDR_W'(OFF_STAT): rdata_o = DATA_W'(stat_i);
        ADDR_W'(OFF_MASK): rdata_o = DATA_W'(mask_i);
        ADDR_W'(OFF_ECTL): rdata_o = DATA_W'(ctl_i);
        ADDR_W'(OFF_IMPL): rdata_o = DATA_W'(impl_i);
        ADDR_W'(OFF_DBG):  rdata_o = DATA_W'(dbg_i);
        default:           rdata_o = '0; // enable, disable, unmapped
      endcase
    end
  end

endmodule

// File: rtl/ramc_irq_regs.sv
module ramc_irq_regs
  import ramc_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned RAM_KIB = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o
);

  localparam int unsigned CTRL_W = 4;
  localparam int unsigned DBG_W  = 16;
  localparam int unsigned USED_W = (NUM_SRC > CTRL_W) ? NUM_SRC : CTRL_W;

  logic               wr, rd;
  logic [NUM_SRC-1:0] stat_q, mask_q;
  logic [CTRL_W-1:0]  ctl_q;
  logic [3:0]         impl;
  logic [DBG_W-1:0]   dbg;
  logic               unused_wdata_hi;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;
  assign unused_wdata_hi = ^wdata_i[31:USED_W];

  ramc_irq_status #(.NUM_SRC(NUM_SRC)) i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .clr_we_i (wr && addr_i == ADDR_W'(OFF_STAT)),
    .en_we_i  (wr && addr_i == ADDR_W'(OFF_EN)),
    .dis_we_i (wr && addr_i == ADDR_W'(OFF_DIS)),
    .wbits_i  (wdata_i[NUM_SRC-1:0]),
    .stat_o   (stat_q),
    .mask_o   (mask_q),
    .irq_o    (irq_o)
  );

  ramc_irq_cfg #(.RAM_KIB(RAM_KIB), .CTRL_W(CTRL_W), .DBG_W(DBG_W)) i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_we_i    (wr && addr_i == ADDR_W'(OFF_ECTL)),
    .ctl_wbits_i (wdata_i[CTRL_W-1:0]),
    .ctl_o       (ctl_q),
    .impl_o      (impl),
    .dbg_o       (dbg)
  );

  ramc_irq_rdmux #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .DBG_W(DBG_W)
  ) i_rdmux (
    .rd_en_i (rd),
    .addr_i  (addr_i),
    .stat_i  (stat_q),
    .mask_i  (mask_q),
    .ctl_i   (ctl_q),
    .impl_i  (impl),
    .dbg_i   (dbg),
    .rdata_o (rdata_o)
  );

endmodule

// File: rtl/ramc_irq_regs_chk.sv
module ramc_irq_regs_chk
  import ramc_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned ADDR_W  = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        wdata_i,
  input logic [NUM_SRC-1:0] evt_i,
  input logic [31:0]        rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] mask_q
);

  logic [NUM_SRC-1:0] wd;
  logic               wr_stat, wr_mask, wr_en, wr_dis;

  assign wd      = wdata_i[NUM_SRC-1:0];
  assign wr_stat = req_i && we_i && addr_i == ADDR_W'(OFF_STAT);
  assign wr_mask = req_i && we_i && addr_i == ADDR_W'(OFF_MASK);
  assign wr_en   = req_i && we_i && addr_i == ADDR_W'(OFF_EN);
  assign wr_dis  = req_i && we_i && addr_i == ADDR_W'(OFF_DIS);

  a_r1_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  a_r1_resv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(OFF_STAT)) |-> (rdata_o[31:NUM_SRC] == '0));

  a_r2_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat |=> ((stat_q & $past(wd & ~evt_i)) == '0));

  a_r3_mask_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> $stable(mask_q));

  a_r4_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> ((mask_q & $past(wd)) == '0));

  a_r5_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dis |=> ((mask_q & $past(wd)) == $past(wd)));

  a_r6_all_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |-> !irq_o);

  a_r6_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat_q != '0));

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> (rdata_o == '0));

endmodule

bind ramc_irq_regs ramc_irq_regs_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .evt_i   (evt_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .stat_q  (stat_q),
  .mask_q  (mask_q)
);

// File: tb/test_ramc_irq_regs.sv
module test_ramc_irq_regs;

  typedef struct packed {
    logic        we;
    logic [3:0]  waddr;
    logic [31:0] wdata;
    logic [10:0] evt;
    logic [3:0]  raddr;
    logic [31:0] exp;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  // we waddr wdata evt raddr exp irq req
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd0, 32'h0,        11'h000, 4'd1, 32'h7FF, 1'b0, 4'd3},  // R3 reset mask
    '{1'b0, 4'd0, 32'h0,        11'h001, 4'd0, 32'h001, 1'b0, 4'd1},  // R1 event set, masked
    '{1'b1, 4'd2, 32'h001,      11'h000, 4'd1, 32'h7FE, 1'b1, 4'd4},  // R4 enable bit0
    '{1'b1, 4'd7, 32'hFFFF,     11'h000, 4'd2, 32'h0,   1'b1, 4'd4},  // R4 enable reads 0, R10 write
    '{1'b1, 4'd7, 32'h0,        11'h000, 4'd3, 32'h0,   1'b1, 4'd5},  // R5 disable reads 0
    '{1'b1, 4'd0, 32'h001,      11'h000, 4'd0, 32'h0,   1'b0, 4'd2},  // R2 w1c
    '{1'b0, 4'd0, 32'h0,        11'h404, 4'd0, 32'h404, 1'b0, 4'd6},  // R6 masked sources quiet
    '{1'b1, 4'd2, 32'h400,      11'h000, 4'd1, 32'h3FE, 1'b1, 4'd6},  // R6 unmask bit10
    '{1'b1, 4'd3, 32'h400,      11'h000, 4'd1, 32'h7FE, 1'b0, 4'd5},  // R5 disable bit10
    '{1'b1, 4'd1, 32'h0,        11'h000, 4'd1, 32'h7FE, 1'b0, 4'd3},  // R3 mask write ignored
    '{1'b1, 4'd0, 32'h404,      11'h004, 4'd0, 32'h004, 1'b0, 4'd2},  // R2 set wins
    '{1'b1, 4'd0, 32'hFFFFFFFF, 11'h000, 4'd0, 32'h0,   1'b0, 4'd1},  // R1 upper zero
    '{1'b1, 4'd4, 32'hFFFFFFA5, 11'h000, 4'd4, 32'h5,   1'b0, 4'd7},  // R7 write
    '{1'b1, 4'd5, 32'hF,        11'h000, 4'd5, 32'h4,   1'b0, 4'd8},  // R8 read-only
    '{1'b1, 4'd6, 32'h0,        11'h000, 4'd6, 32'hFFFF,1'b0, 4'd9},  // R9 read-only
    '{1'b0, 4'd0, 32'h0,        11'h000, 4'd15,32'h0,   1'b0, 4'd10}, // R10 unmapped read
    '{1'b1, 4'd2, 32'hFFFFFFFF, 11'h7FF, 4'd1, 32'h0,   1'b1, 4'd4},  // R4 enable all
    '{1'b0, 4'd0, 32'h0,        11'h000, 4'd0, 32'h7FF, 1'b1, 4'd1},  // R1 all set
    '{1'b1, 4'd3, 32'hFFFFFFFF, 11'h000, 4'd1, 32'h7FF, 1'b0, 4'd5},  // R5 disable all
    '{1'b1, 4'd2, 32'h002,      11'h000, 4'd1, 32'h7FD, 1'b1, 4'd6},  // R6 one source live
    '{1'b1, 4'd0, 32'h002,      11'h000, 4'd0, 32'h7FD, 1'b0, 4'd6}   // R6 drops after clear
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [10:0] evt_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  ramc_irq_regs i_ramc_irq_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .evt_i, .rdata_o, .irq_o
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, string tag, logic [31:0] exp);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a; evt_i = '0;
    #1 check(tag, rdata_o, exp);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      finish_run();
    end
  end

  initial begin
    #1 check("R10 idle in reset", rdata_o, 32'h0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // reset state
    rd(4'd0, "R1 status reset", 32'h0);
    rd(4'd1, "R3 mask reset", 32'h7FF);
    rd(4'd4, "R7 errctl reset", 32'hF);
    rd(4'd5, "R8 size code 1MiB", 32'h4);
    rd(4'd6, "R9 debug reset", 32'hFFFF);
    check("R6 irq reset", {31'b0, irq_o}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      req_i = VEC[v].we; we_i = VEC[v].we;
      addr_i = VEC[v].waddr; wdata_i = VEC[v].wdata; evt_i = VEC[v].evt;
      @(negedge clk_i);
      req_i = 1'b1; we_i = 1'b0; addr_i = VEC[v].raddr; evt_i = '0; wdata_i = '0;
      #1;
      check($sformatf("R%0d vector %0d data", VEC[v].req, v), rdata_o, VEC[v].exp);
      check($sformatf("R%0d vector %0d irq", VEC[v].req, v), {31'b0, irq_o}, {31'b0, VEC[v].irq});
    end

    // R10: idle bus returns zero even at a mapped offset
    @(negedge clk_i);
    req_i = 1'b0; addr_i = 4'd1;
    #1 check("R10 idle read", rdata_o, 32'h0);

    // R6: state before reset has irq high; reset restores defaults
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 4'd2; wdata_i = 32'h7FF;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    #1 check("R6 irq before reset", {31'b0, irq_o}, 32'h1);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    rd(4'd1, "R3 mask after reset", 32'h7FF);
    rd(4'd0, "R1 status after reset", 32'h0);
    rd(4'd4, "R7 errctl after reset", 32'hF);
    check("R6 irq after reset", {31'b0, irq_o}, 32'h0);

    @(negedge clk_i);
    req_i = 1'b0;
    done = 1'b1;
    finish_run();
  end

endmodule